// File: doc/BRIEF.md
# Direct-Mapped Cache Controller

This block is a small direct-mapped cache placed between a word-addressed processor port and a word-addressed main memory. Each processor address is cut into three fields. From the most significant end these are the tag, the line index and the word offset. The indexed line's stored tag and valid bit decide whether the access hits. On a read miss the controller fetches every word of the block from memory, one word per cycle, before it answers. Only the tag is stored with a line. The index is implied by the line's position, so blocks whose numbers are equal modulo the line count compete for the same line.

Two build-time parameters choose the write policy. `WRITE_BACK` selects write-back, where a dirty bit is set and the line is flushed before it is replaced, or write-through. `WRITE_ALLOC` selects write-allocate or no-write-allocate. Two counters record accepted accesses and hits, so a test can check the hit ratio.

The processor port follows a valid/ready rule. A request is taken on a clock edge where both `cpu_req` and `cpu_ready` are high. `cpu_ready` is low for as long as a miss is being served, and the requester must hold its request until it is taken. The response is a one-cycle `cpu_rvalid` pulse and has no back-pressure. The memory port is plain: it accepts a strobe every cycle, and read data returns on the cycle after the strobe.

Top module: `dmc_cache`

## Requirements
- R1: With the default geometry (4 lines of 4 words, 6-bit address), the address is split from the top down as tag = addr[5:4], index = addr[3:2] and offset = addr[1:0]. Two blocks with the same index evict each other.
- R2: After reset every line is invalid, so the first access to any line misses. After reset `cpu_ready` is 1, `cpu_rvalid` is 0 and both counters are 0.
- R3: A read hit raises `cpu_rvalid` on the same clock edge that accepts the request, with `cpu_hit`=1 and the stored word on `cpu_rdata`.
- R4: A read miss on a clean or invalid line fills the whole block from memory, one word per cycle. The response comes WORDS+2 edges after acceptance with `cpu_hit`=0. The other words of that block hit afterwards.
- R5: In write-through mode a write hit writes memory on the accepting edge and also updates the line.
- R6: In write-back mode a write hit updates only the line and marks it dirty. It issues no memory write.
- R7: Before a dirty line is replaced, its WORDS words are written back to their old block address. This adds WORDS cycles to the miss.
- R8: With write-allocate, a write miss first fills the block and then applies the write under the hit policy. Later reads of that word hit and return the written data.
- R9: With no-write-allocate, a write miss writes memory only and answers on the accepting edge with `cpu_hit`=0. The line is not allocated.
- R10: `access_count` rises by one per accepted request and `hit_count` by one per accepted hit. Both saturate, and hits never exceed accesses.
- R11: While a miss is in progress `cpu_ready` stays 0, and a request presented then is not counted as accepted. For a write, `cpu_rdata` echoes the written word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request valid |
| cpu_ready | output | 1 | Controller can take a request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rvalid | output | 1 | One-cycle response pulse |
| cpu_rdata | output | DATA_W | Read data, or the echoed write data |
| cpu_hit | output | 1 | Response was a hit |
| mem_en | output | 1 | Memory strobe |
| mem_we | output | 1 | Memory write when strobed |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, one cycle after a read strobe |
| hit_count | output | CNT_W | Accepted hits |
| access_count | output | CNT_W | Accepted requests |

## Verification
Two things can coincide on one clock edge. The first is the capture of the last fill word, which also installs the tag, together with the completion of a pending allocated write into that same line. The second is a dirty victim whose flush must finish before the new block's fill reads from the same memory. The bench provokes the first with a write miss under write-allocate. It provokes the second by dirtying a line and then reading a conflicting block, and afterwards reads the flushed word back through a fresh miss. Results are judged at the ports only: response data, the hit flag, latency in edges, counts of memory writes, and the contents of the bench's memory model.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WBACK = 2'd1,
    ST_FILL  = 2'd2,
    ST_DONE  = 2'd3
  } dmc_state_e;
endpackage

// File: rtl/dmc_addr_fields.sv
module dmc_addr_fields #(
  parameter int ADDR_W = 6,
  parameter int IDX_W  = 2,
  parameter int OFF_W  = 2,
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [TAG_W-1:0]  tag,
  output logic [IDX_W-1:0]  idx,
  output logic [OFF_W-1:0]  off
);
  // Tag on top, then index, then word offset.
  assign off = addr[OFF_W-1:0];
  assign idx = addr[OFF_W +: IDX_W];
  assign tag = addr[ADDR_W-1 -: TAG_W];
endmodule

// File: rtl/dmc_line_store.sv
module dmc_line_store #(
  parameter int LINES  = 4,
  parameter int WORDS  = 4,
  parameter int DATA_W = 16,
  parameter int TAG_W  = 2,
  localparam int IDX_W = $clog2(LINES),
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [TAG_W-1:0]  rd_tag,
  output logic              rd_valid,
  output logic              rd_dirty,
  output logic [DATA_W-1:0] rd_word,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              inst_en,
  input  logic [IDX_W-1:0]  inst_idx,
  input  logic [TAG_W-1:0]  inst_tag,
  input  logic              dset_en,
  input  logic              dclr_en,
  input  logic [IDX_W-1:0]  d_idx
);
  logic [TAG_W-1:0]  tag_q   [LINES];
  logic [LINES-1:0]  valid_q;
  logic [LINES-1:0]  dirty_q;
  logic [DATA_W-1:0] data_q  [LINES*WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
      for (int l = 0; l < LINES; l++) tag_q[l] <= '0;
    end else begin
      if (inst_en) begin
        valid_q[inst_idx] <= 1'b1;
        tag_q[inst_idx]   <= inst_tag;
      end
      if (dclr_en) dirty_q[d_idx] <= 1'b0;
      if (dset_en) dirty_q[d_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) data_q[{wr_idx, wr_off}] <= wr_data;
  end

  assign rd_tag   = tag_q[rd_idx];
  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_word  = data_q[{rd_idx, rd_off}];

  // A new block never lands on a line still holding unflushed data.
  AST_NO_DIRTY_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    inst_en |-> !(valid_q[inst_idx] && dirty_q[inst_idx])); // R7
endmodule

// File: rtl/dmc_hit_stats.sv
module dmc_hit_stats #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_en,
  input  logic             hit_en,
  output logic [CNT_W-1:0] hit_count,
  output logic [CNT_W-1:0] access_count
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_count    <= '0;
      access_count <= '0;
    end else begin
      if (acc_en && access_count != CMAX) access_count <= access_count + 1'b1;
      if (hit_en && hit_count != CMAX)    hit_count    <= hit_count + 1'b1;
    end
  end

  AST_HIT_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    hit_en |-> acc_en); // R10
  AST_HITS_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    hit_count <= access_count); // R10
endmodule

// File: rtl/dmc_cache.sv
module dmc_cache #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int LINES       = 4,
  parameter int WORDS       = 4,
  parameter bit WRITE_BACK  = 1'b1,
  parameter bit WRITE_ALLOC = 1'b1,
  parameter int CNT_W       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  output logic              cpu_ready,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_rvalid,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_hit,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  access_count
);
  import dmc_pkg::*;

  localparam int IDX_W = $clog2(LINES);
  localparam int OFF_W = $clog2(WORDS);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(WORDS - 1);
  localparam logic [OFF_W:0]   WORDS_C  = (OFF_W+1)'(WORDS);

  dmc_state_e        state_q;
  logic              q_we;
  logic [ADDR_W-1:0] q_addr;
  logic [DATA_W-1:0] q_wdata;
  logic [OFF_W:0]    iss_q;
  logic [OFF_W-1:0]  rcv_q;
  logic              pend_q;

  logic [ADDR_W-1:0] sel_addr;
  logic [TAG_W-1:0]  s_tag;
  logic [IDX_W-1:0]  s_idx;
  logic [OFF_W-1:0]  s_off;
  logic [TAG_W-1:0]  rd_tag;
  logic              rd_valid, rd_dirty;
  logic [DATA_W-1:0] rd_word;
  logic [OFF_W-1:0]  rd_off;
  logic              wr_en, inst_en, dset_en, dclr_en;
  logic [OFF_W-1:0]  wr_off;
  logic [DATA_W-1:0] wr_data;
  logic              lookup_hit, accept, issue;

  assign cpu_ready  = (state_q == ST_IDLE);
  assign accept     = cpu_req && cpu_ready;
  assign sel_addr   = (state_q == ST_IDLE) ? cpu_addr : q_addr;
  assign rd_off     = (state_q == ST_WBACK) ? iss_q[OFF_W-1:0] : s_off;
  assign lookup_hit = rd_valid && (rd_tag == s_tag);
  assign issue      = (state_q == ST_FILL) && (iss_q < WORDS_C);

  dmc_addr_fields #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_fields (
    .addr(sel_addr), .tag(s_tag), .idx(s_idx), .off(s_off)
  );

  dmc_line_store #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(s_idx), .rd_off(rd_off),
    .rd_tag(rd_tag), .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_word(rd_word),
    .wr_en(wr_en), .wr_idx(s_idx), .wr_off(wr_off), .wr_data(wr_data),
    .inst_en(inst_en), .inst_idx(s_idx), .inst_tag(s_tag),
    .dset_en(dset_en), .dclr_en(dclr_en), .d_idx(s_idx)
  );

  dmc_hit_stats #(.CNT_W(CNT_W)) u_stats (
    .clk(clk), .rst_n(rst_n),
    .acc_en(accept), .hit_en(accept && lookup_hit),
    .hit_count(hit_count), .access_count(access_count)
  );

  // Array writes and the memory port, decoded from state.
  always_comb begin
    wr_en     = 1'b0;
    wr_off    = s_off;
    wr_data   = cpu_wdata;
    inst_en   = 1'b0;
    dset_en   = 1'b0;
    dclr_en   = 1'b0;
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = sel_addr;
    mem_wdata = cpu_wdata;
    unique case (state_q)
      ST_IDLE: begin
        if (accept && cpu_we) begin
          if (lookup_hit) begin
            wr_en   = 1'b1;
            dset_en = WRITE_BACK;
            mem_en  = !WRITE_BACK;
            mem_we  = !WRITE_BACK;
          end else if (!WRITE_ALLOC) begin
            mem_en = 1'b1;
            mem_we = 1'b1;
          end
        end
      end
      ST_WBACK: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {rd_tag, s_idx, iss_q[OFF_W-1:0]};
        mem_wdata = rd_word;
        dclr_en   = (iss_q[OFF_W-1:0] == LAST_OFF);
      end
      ST_FILL: begin
        mem_en   = issue;
        mem_addr = {s_tag, s_idx, iss_q[OFF_W-1:0]};
        wr_en    = pend_q;
        wr_off   = rcv_q;
        wr_data  = mem_rdata;
        inst_en  = pend_q && (rcv_q == LAST_OFF);
      end
      ST_DONE: begin
        if (q_we) begin
          wr_en     = 1'b1;
          wr_data   = q_wdata;
          dset_en   = WRITE_BACK;
          mem_en    = !WRITE_BACK;
          mem_we    = !WRITE_BACK;
          mem_wdata = q_wdata;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      q_we       <= 1'b0;
      q_addr     <= '0;
      q_wdata    <= '0;
      iss_q      <= '0;
      rcv_q      <= '0;
      pend_q     <= 1'b0;
      cpu_rvalid <= 1'b0;
      cpu_rdata  <= '0;
      cpu_hit    <= 1'b0;
    end else begin
      cpu_rvalid <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (lookup_hit || (cpu_we && !WRITE_ALLOC)) begin
              cpu_rvalid <= 1'b1;
              cpu_hit    <= lookup_hit;
              cpu_rdata  <= cpu_we ? cpu_wdata : rd_word;
            end else begin
              q_we    <= cpu_we;
              q_addr  <= cpu_addr;
              q_wdata <= cpu_wdata;
              iss_q   <= '0;
              rcv_q   <= '0;
              pend_q  <= 1'b0;
              state_q <= (WRITE_BACK && rd_valid && rd_dirty) ? ST_WBACK : ST_FILL;
            end
          end
        end
        ST_WBACK: begin
          if (iss_q[OFF_W-1:0] == LAST_OFF) begin
            iss_q   <= '0;
            state_q <= ST_FILL;
          end else begin
            iss_q <= iss_q + 1'b1;
          end
        end
        ST_FILL: begin
          pend_q <= issue;
          if (issue) iss_q <= iss_q + 1'b1;
          if (pend_q) begin
            rcv_q <= rcv_q + 1'b1;
            if (rcv_q == LAST_OFF) state_q <= ST_DONE;
          end
        end
        ST_DONE: begin
          cpu_rvalid <= 1'b1;
          cpu_hit    <= 1'b0;
          cpu_rdata  <= q_we ? q_wdata : rd_word;
          state_q    <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_BUSY_NOT_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_ready) |=> (access_count == $past(access_count))); // R11
  AST_FILL_RUNS_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FILL) |=> (state_q == ST_FILL || state_q == ST_DONE)); // R4
  AST_RESP_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rvalid |-> cpu_ready); // R3

  generate
    if (WRITE_BACK) begin : g_wb_chk
      AST_WB_MEM_WRITE_ONLY_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we && state_q != ST_WBACK) |-> (state_q == ST_IDLE && !WRITE_ALLOC)); // R6
    end else begin : g_wt_chk
      AST_WT_NO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != ST_WBACK); // R5
    end
  endgenerate
endmodule

// File: tb/tb_dmc_cache.sv
`timescale 1ns/1ps
module tb_dmc_cache;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  // Index 0: write-back + write-allocate (dut). Index 1: write-through + no-allocate (dut_wt).
  logic        req [2];
  logic        rdy [2];
  logic        we  [2];
  logic [5:0]  addr [2];
  logic [15:0] wdata [2];
  logic        rvalid [2];
  logic [15:0] rdata [2];
  logic        hit [2];
  logic        m_en [2];
  logic        m_we [2];
  logic [5:0]  m_addr [2];
  logic [15:0] m_wdata [2];
  logic [15:0] m_rdata [2];
  logic [15:0] hcnt [2];
  logic [15:0] acnt [2];
  logic [15:0] mem [2][64];
  int          wr_cnt [2];

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  dmc_cache dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(req[0]), .cpu_ready(rdy[0]), .cpu_we(we[0]),
    .cpu_addr(addr[0]), .cpu_wdata(wdata[0]), .cpu_rvalid(rvalid[0]), .cpu_rdata(rdata[0]),
    .cpu_hit(hit[0]), .mem_en(m_en[0]), .mem_we(m_we[0]), .mem_addr(m_addr[0]),
    .mem_wdata(m_wdata[0]), .mem_rdata(m_rdata[0]), .hit_count(hcnt[0]), .access_count(acnt[0])
  );

  dmc_cache #(.WRITE_BACK(1'b0), .WRITE_ALLOC(1'b0)) dut_wt (
    .clk(clk), .rst_n(rst_n), .cpu_req(req[1]), .cpu_ready(rdy[1]), .cpu_we(we[1]),
    .cpu_addr(addr[1]), .cpu_wdata(wdata[1]), .cpu_rvalid(rvalid[1]), .cpu_rdata(rdata[1]),
    .cpu_hit(hit[1]), .mem_en(m_en[1]), .mem_we(m_we[1]), .mem_addr(m_addr[1]),
    .mem_wdata(m_wdata[1]), .mem_rdata(m_rdata[1]), .hit_count(hcnt[1]), .access_count(acnt[1])
  );

  for (genvar g = 0; g < 2; g++) begin : g_mem
    always @(posedge clk) begin
      if (m_en[g]) begin
        if (m_we[g]) begin
          mem[g][m_addr[g]] <= m_wdata[g];
          wr_cnt[g] <= wr_cnt[g] + 1;
        end else begin
          m_rdata[g] <= mem[g][m_addr[g]];
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input int i, input bit w, input logic [5:0] a, input logic [15:0] d,
                        output bit h, output logic [15:0] r, output int lat, output bit busy_rdy);
    @(negedge clk);
    req[i] = 1'b1; we[i] = w; addr[i] = a; wdata[i] = d;
    @(posedge clk);
    #1 req[i] = 1'b0;
    lat = 0;
    busy_rdy = 1'b0;
    while (!rvalid[i]) begin
      if (rdy[i]) busy_rdy = 1'b1;
      @(posedge clk);
      #1 lat++;
    end
    h = hit[i];
    r = rdata[i];
  endtask

  // {inst, we, addr, wdata, exp_hit, exp_rdata, exp_latency}
  localparam int NV = 15;
  localparam logic [44:0] VEC [NV] = '{
    {1'b0, 1'b0, 6'h11, 16'h0000, 1'b0, 16'h1011, 4'd6 },  // R2 R4 cold miss
    {1'b0, 1'b0, 6'h13, 16'h0000, 1'b1, 16'h1013, 4'd0 },  // R3 R4 same block hits
    {1'b0, 1'b1, 6'h12, 16'hBEEF, 1'b1, 16'hBEEF, 4'd0 },  // R6 write hit, dirty
    {1'b0, 1'b0, 6'h12, 16'h0000, 1'b1, 16'hBEEF, 4'd0 },  // R3
    {1'b0, 1'b0, 6'h31, 16'h0000, 1'b0, 16'h1031, 4'd10},  // R1 R7 conflict, flush first
    {1'b0, 1'b0, 6'h12, 16'h0000, 1'b0, 16'hBEEF, 4'd6 },  // R1 R7 flushed data returns
    {1'b0, 1'b1, 6'h25, 16'h1234, 1'b0, 16'h1234, 4'd6 },  // R8 allocate then write
    {1'b0, 1'b0, 6'h25, 16'h0000, 1'b1, 16'h1234, 4'd0 },  // R8
    {1'b0, 1'b0, 6'h24, 16'h0000, 1'b1, 16'h1024, 4'd0 },  // R8 rest of block filled
    {1'b1, 1'b0, 6'h05, 16'h0000, 1'b0, 16'h1005, 4'd6 },  // R4
    {1'b1, 1'b1, 6'h06, 16'hCAFE, 1'b1, 16'hCAFE, 4'd0 },  // R5 write-through hit
    {1'b1, 1'b0, 6'h06, 16'h0000, 1'b1, 16'hCAFE, 4'd0 },  // R5
    {1'b1, 1'b1, 6'h3A, 16'h7777, 1'b0, 16'h7777, 4'd0 },  // R9 memory-only write
    {1'b1, 1'b0, 6'h3A, 16'h0000, 1'b0, 16'h7777, 4'd6 },  // R9 not allocated
    {1'b1, 1'b0, 6'h3B, 16'h0000, 1'b1, 16'h103B, 4'd0 }   // R4
  };

  initial begin
    for (int g = 0; g < 2; g++) begin
      for (int a = 0; a < 64; a++) mem[g][a] = 16'h1000 + 16'(a);
      req[g] = 1'b0; we[g] = 1'b0; addr[g] = '0; wdata[g] = '0;
      wr_cnt[g] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    for (int g = 0; g < 2; g++) begin
      chk("R2 ready after reset", 32'(rdy[g]), 32'd1);
      chk("R2 no response after reset", 32'(rvalid[g]), 32'd0);
      chk("R2 access count zero", 32'(acnt[g]), 32'd0);
      chk("R2 hit count zero", 32'(hcnt[g]), 32'd0);
    end

    for (int v = 0; v < NV; v++) begin
      bit h; logic [15:0] r; int lat; bit br;
      int i;
      i = int'(VEC[v][44]);
      access(i, VEC[v][43], VEC[v][42:37], VEC[v][36:21], h, r, lat, br);
      chk($sformatf("R3 R4 R8 R9 vec%0d rdata", v), 32'(r), 32'(VEC[v][19:4]));
      chk($sformatf("R3 R4 R9 vec%0d hit flag", v), 32'(h), 32'(VEC[v][20]));
      chk($sformatf("R4 R7 vec%0d latency", v), 32'(lat), 32'(VEC[v][3:0]));
      chk($sformatf("R11 vec%0d ready low while busy", v), 32'(br), 32'd0);
    end

    // Directed corners after the table.
    @(negedge clk);
    chk("R10 wb accesses", 32'(acnt[0]), 32'd9);
    chk("R10 wb hits", 32'(hcnt[0]), 32'd5);
    chk("R10 wt accesses", 32'(acnt[1]), 32'd6);
    chk("R10 wt hits", 32'(hcnt[1]), 32'd3);
    chk("R6 R7 wb memory writes are the one flush", 32'(wr_cnt[0]), 32'd4);
    chk("R7 flushed word in memory", 32'(mem[0][6'h12]), 32'hBEEF);
    chk("R7 flushed clean word", 32'(mem[0][6'h13]), 32'h1013);
    chk("R6 allocated dirty word not yet in memory", 32'(mem[0][6'h25]), 32'h1025);
    chk("R5 R9 wt memory writes", 32'(wr_cnt[1]), 32'd2);
    chk("R5 write-through word in memory", 32'(mem[1][6'h06]), 32'hCAFE);
    chk("R9 memory-only write landed", 32'(mem[1][6'h3A]), 32'h7777);

    // R11: a request presented during a miss is not taken until ready returns.
    begin
      int n;
      @(negedge clk);
      req[0] = 1'b1; we[0] = 1'b0; addr[0] = 6'h08;   // idx 2, cold
      @(posedge clk);
      #1 addr[0] = 6'h0A;                             // held request, same block
      n = 0;
      while (!rvalid[0]) begin @(posedge clk); #1 n++; end
      chk("R11 only first request counted during miss", 32'(acnt[0]), 32'd10);
      chk("R4 first response data", 32'(rdata[0]), 32'h1008);
      @(posedge clk);
      #1 req[0] = 1'b0;
      chk("R11 held request taken once ready", 32'(acnt[0]), 32'd11);
      chk("R3 held request hits", 32'(hcnt[0]), 32'd6);
      chk("R3 held request data", 32'(rdata[0]), 32'h100A);
      chk("R3 held request flag", 32'(hit[0]), 32'd1);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule